// File: doc/BRIEF.md
# Twin Down-Counter Timer

This block holds two independent down counters, each of `CNT_W` bits (16 by default). A counter steps down by one on every tick of its chosen time base. When it steps down from zero, it either wraps to all ones and keeps counting (free-run mode) or reloads the last value written to its load register (reload mode). In both modes it raises a one-cycle underflow pulse on its own interrupt line.

A timer reference strobe enters the block from outside. A shared prescaler counts every strobe from reset and produces a divided strobe once every 256 reference strobes. A per-timer select bit in the shared control register picks either that divided strobe or the raw reference strobe.

Software writes a load register for each timer and one control register through a small write port. It reads the live counters or the control register back through a registered read port.

Top module: `twin_down_timer`

## Requirements
- R1: After synchronous reset, both counters, both reload values and the control register are 0, both interrupt lines are low, and a read at any address returns 0.
- R2: A write to address 0 (timer 0) or address 1 (timer 1) sets that timer's counter and reload value to `wr_data` in the same edge, in either mode. If a tick for that timer arrives in the same cycle, the write wins.
- R3: On a selected tick a counter that is not zero drops by exactly one. Without a tick or a load write the counter holds its value.
- R4: In free-run mode (mode bit 0), a tick at count 0 sets the counter to all ones.
- R5: In reload mode (mode bit 1), a tick at count 0 sets the counter to the last value written to its load register.
- R6: A tick at count 0 raises that timer's interrupt bit (`irq[0]` for timer 0, `irq[1]` for timer 1) for exactly the one cycle after that edge, in both modes.
- R7: The clock select of timer 0 is control bit 5 and that of timer 1 is control bit 7. A value of 1 ticks on every reference strobe, and a value of 0 ticks on the divided strobe (reference divided by 256).
- R8: The mode bit of timer 0 is control bit 4 and that of timer 1 is control bit 6. Each timer follows its own bits, so the two timers may run in different modes at once. A write to address 2 loads the control register from `wr_data[7:0]`.
- R9: The prescaler is shared by both timers and runs freely from reset. The divided strobe coincides with the 256th reference strobe after reset, and with every 256th strobe after that.
- R10: `rd_data` shows, one cycle after `rd_addr` is presented, the live value of counter 0 (address 0), counter 1 (address 1) or the zero-extended control register (address 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Timer reference strobe, one cycle per pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 load timer 0, 1 load timer 1, 2 control |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address: 0 counter 0, 1 counter 1, 2 control |
| rd_data | output | CNT_W | Registered read data |
| irq | output | 2 | Per-timer underflow pulses |

## Verification
The bench builds the block with its defaults, `CNT_W` = 16 and `DIV_LOG2` = 8. With these values the wrap to 0xFFFF is the real 16-bit one, and the divided strobe lands on the true 256th reference strobe. That boundary is reached within a few hundred strobes, so the bench reads a counter just before and just after it. A reference model of both counters and of the prescaler phase predicts every read and every interrupt pulse. The runs cover mixed modes, mixed clock selects and a load write that lands on the same cycle as a tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ADDR_LD0  = 2'd0,
    ADDR_LD1  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_NONE = 2'd3
  } tmr_addr_e;

  localparam int NUM_TMR = 2;
  localparam int CTRL_W  = 8;

  // control bit positions: mode at 4 + 2*i, clock select at 5 + 2*i
  function automatic int mode_bit(input int idx);
    return 4 + 2 * idx;
  endfunction

  function automatic int sel_bit(input int idx);
    return 5 + 2 * idx;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  output logic div_tick
);
  logic [DIV_LOG2-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (ref_tick) phase_q <= phase_q + 1'b1;
  end

  assign div_tick = ref_tick && (&phase_q);

  // R9
  pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> $stable(phase_q));

  // R9
  pre_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    div_tick |=> (phase_q == '0));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             ref_tick,
  input  logic             div_tick,
  input  logic             sel_fast,
  input  logic             mode_rld,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] rld_q;
  logic             tick;

  assign tick = sel_fast ? ref_tick : div_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (ld_en) begin
        cnt_q <= ld_val;
        rld_q <= ld_val;
      end else if (tick) begin
        if (cnt_q == '0) begin
          cnt_q <= mode_rld ? rld_q : '1;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (cnt_q == $past(ld_val)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !tick) |=> $stable(cnt_q));

  // R3
  dec_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && tick && cnt_q == '0 && !mode_rld) |=> (&cnt_q));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && tick && cnt_q == '0 && mode_rld) |=> (cnt_q == $past(rld_q)));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> ($past(cnt_q) == '0 && !$past(ld_en)));
endmodule

// File: rtl/twin_down_timer.sv
module twin_down_timer #(
  parameter int CNT_W    = 16,
  parameter int DIV_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [1:0]       irq
);
  import tmr_pkg::*;

  localparam int PAD_W = CNT_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic              div_tick;
  logic [CNT_W-1:0]  cnt_arr [NUM_TMR];
  logic [NUM_TMR-1:0] irq_arr;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  tmr_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .div_tick (div_tick)
  );

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    logic ld_hit;
    assign ld_hit = wr_en && (wr_addr == 2'(gi));

    tmr_unit #(.CNT_W(CNT_W)) u_unit (
      .clk      (clk),
      .rst      (rst),
      .ld_en    (ld_hit),
      .ld_val   (wr_data),
      .ref_tick (ref_tick),
      .div_tick (div_tick),
      .sel_fast (ctrl_q[sel_bit(gi)]),
      .mode_rld (ctrl_q[mode_bit(gi)]),
      .cnt_q    (cnt_arr[gi]),
      .irq_q    (irq_arr[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_LD0:  rd_data <= cnt_arr[0];
        ADDR_LD1:  rd_data <= cnt_arr[1];
        ADDR_CTRL: rd_data <= {{PAD_W{1'b0}}, ctrl_q};
        default:   rd_data <= '0;
      endcase
    end
  end

  assign irq = irq_arr;

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADDR_CTRL) |=> $stable(ctrl_q));

  // R7
  slow_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[5] && !ref_tick && !(wr_en && wr_addr == ADDR_LD0)) |=> $stable(cnt_arr[0]));
endmodule

// File: tb/twin_down_timer_bench.sv
module twin_down_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ref_tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [1:0]   irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  int unsigned m_cnt [2];
  int unsigned m_rld [2];
  int unsigned m_ctrl = 0;
  int unsigned ref_total = 0;
  bit          irq_exp [2];

  // scoreboard
  int unsigned exp_q [$];
  string       tag_q [$];
  logic        rd_req = 1'b0;
  logic        req_q = 1'b0;

  twin_down_timer #(.CNT_W(W), .DIV_LOG2(8)) u_twin_down_timer (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) req_q <= rd_req;

  always @(negedge clk) begin
    if (req_q) begin
      int unsigned e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rd_data !== W'(e)) begin
        bad++;
        $display("FAIL %s: read actual=%h expected=%h", t, rd_data, W'(e));
      end
    end
  end

  task automatic check_bit(input logic act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic void model_step(input int skip);
    bit dv;
    ref_total++;
    dv = (ref_total % 256) == 0;
    for (int i = 0; i < 2; i++) begin
      bit tk;
      irq_exp[i] = 0;
      tk = m_ctrl[5 + 2*i] ? 1'b1 : dv;
      if (i != skip && tk) begin
        if (m_cnt[i] == 0) begin
          m_cnt[i] = m_ctrl[4 + 2*i] ? m_rld[i] : 32'hFFFF;
          irq_exp[i] = 1;
        end else begin
          m_cnt[i] = m_cnt[i] - 1;
        end
      end
    end
  endfunction

  function automatic void model_write(input int a, input int unsigned d);
    if (a == 2) m_ctrl = d & 32'hFF;
    else if (a < 2) begin
      m_cnt[a] = d & 32'hFFFF;
      m_rld[a] = d & 32'hFFFF;
    end
  endfunction

  task automatic wr(input int a, input int unsigned d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = W'(d);
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    ref_tick = 1'b1;
    model_step(-1);
    @(negedge clk);
    ref_tick = 1'b0;
    check_bit(irq[0], irq_exp[0], "R6 irq0");
    check_bit(irq[1], irq_exp[1], "R6 irq1");
  endtask

  // load write and reference strobe on the same cycle (R2)
  task automatic wr_pulse(input int a, input int unsigned d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = W'(d); ref_tick = 1'b1;
    model_step(a);
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0; ref_tick = 1'b0;
    check_bit(irq[0], irq_exp[0], "R2 irq0");
    check_bit(irq[1], irq_exp[1], "R2 irq1");
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    rd_addr = 2'(a); rd_req = 1'b1;
    exp_q.push_back(a == 2 ? m_ctrl : m_cnt[a]);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_cnt[0] = 0; m_cnt[1] = 0; m_rld[0] = 0; m_rld[1] = 0;
    irq_exp[0] = 0; irq_exp[1] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_bit(irq[0], 1'b0, "R1 irq0");
    check_bit(irq[1], 1'b0, "R1 irq1");
    rd(0, "R1 cnt0"); rd(1, "R1 cnt1"); rd(2, "R1 ctrl");

    // R10 control readback, both undivided free-run
    wr(2, 32'hA0);
    rd(2, "R10 ctrl");
    // R2 loads
    wr(0, 5); wr(1, 300);
    rd(0, "R2 cnt0"); rd(1, "R2 cnt1");
    // R3 decrement and hold
    repeat (3) pulse();
    rd(0, "R3 dec cnt0"); rd(1, "R10 live cnt1");
    repeat (5) @(negedge clk);
    rd(0, "R3 hold cnt0");
    // R4 wrap
    repeat (3) pulse();
    rd(0, "R4 wrap cnt0");
    // R5 reload, both timers
    wr(2, 32'hF0); wr(0, 2); wr(1, 2);
    repeat (3) pulse();
    rd(0, "R5 reload cnt0"); rd(1, "R5 reload cnt1");
    // R8 mixed modes: timer0 free-run, timer1 reload
    wr(2, 32'hE0); wr(0, 0); wr(1, 0);
    pulse();
    rd(0, "R8 free cnt0"); rd(1, "R8 reload cnt1");
    // R2 write beats same-cycle tick
    wr_pulse(0, 7);
    rd(0, "R2 tick-write cnt0");
    // R7 / R9 divided select on timer0
    wr(2, 32'h80); wr(0, 10);
    while ((ref_total % 256) != 255) pulse();
    rd(0, "R7 before divided tick");
    pulse();
    rd(0, "R9 divided tick");
    repeat (256) pulse();
    rd(0, "R9 second divided tick"); rd(1, "R7 fast cnt1");
    // R7 both divided
    wr(2, 32'h00); wr(1, 1);
    repeat (300) pulse();
    rd(0, "R7 slow cnt0"); rd(1, "R7 slow cnt1");
    repeat (4) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R10: pending reads actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule